// File: doc/BRIEF.md
# Big/Small Core Mix Selector

This block picks, once per decoded video frame, which mix of cores in an eight-core cluster is powered for the next frame. The cluster has four big cores and four small cores that run the same code. The block keeps a signed running balance of time in hand. At every frame-completion strobe it adds the frame's time budget and subtracts the measured decode time. It then compares the updated balance with thresholds at one, one and a half and two times the budget, and registers one of four fixed core mixes.

The chosen mix is given both as a 2-bit code and as an 8-bit enable mask. A power controller and a thread scheduler use these outputs. The block only changes its choice on a frame strobe, so a mix never changes while a frame is being decoded. The balance saturates instead of wrapping. A long run of very fast or very slow frames therefore cannot flip its sign.

Top module: `core_mix_selector`

## Requirements
- R1: After reset the balance is zero and the selection is the ultra-low-power mix: code 3, mask 8'h30.
- R2: On a cycle with `frame_done` high, the balance becomes balance + `budget` - `decode_time`, with both inputs taken as unsigned values.
- R3: While `frame_done` is low, the balance and the selection hold, whatever `budget` and `decode_time` carry.
- R4: If the updated balance is below one budget, the selection is the four-big mix: code 0, mask 8'h0F. Mask bits 3:0 enable big cores 0 to 3, and bits 7:4 enable small cores 0 to 3.
- R5: If the updated balance is at least one budget and below one and a half budgets, the selection is the four-small mix: code 1, mask 8'hF0. One and a half budgets is computed as budget + floor(budget/2).
- R6: If the updated balance is at least one and a half budgets and below two budgets, the selection is one big plus one small: code 2, mask 8'h11 (big core 0 and small core 0).
- R7: If the updated balance is at least two budgets, the selection is two small cores: code 3, mask 8'h30 (small cores 0 and 1).
- R8: The comparison uses the balance after it includes the strobed frame, together with that same cycle's `budget`. The new code and mask appear after the clock edge that samples the strobe.
- R9: The balance is a 19-bit signed value (TIME_W+3). It saturates at 262143 and at -262144 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_done | input | 1 | One-cycle strobe at the end of each decoded frame |
| budget | input | 16 | Time allowed per frame, unsigned |
| decode_time | input | 16 | Measured decode time of the finished frame, unsigned |
| cfg_code | output | 2 | Registered core mix code (0 four big, 1 four small, 2 one big plus one small, 3 two small) |
| core_en | output | 8 | Core enable mask: bits 3:0 big cores, bits 7:4 small cores |

## Verification
The balance update and the threshold selection happen in the same clock edge, so the new code must reflect the balance that already includes the strobed frame. The bench provokes this with directed frames whose slack lands exactly on one, one and a half and two budgets, including an odd budget where the half step rounds down. A correct selection there shows that the fresh sum is compared, and that ties go to the milder mix. Saturation is checked the same way. The bench drives the balance to its upper limit and then applies large overshoots, which must cross zero on the exact frame that a clamped model predicts.

// File: rtl/core_mix_pkg.sv
package core_mix_pkg;
  typedef enum logic [1:0] {
    MIX_BIG4    = 2'd0,
    MIX_SMALL4  = 2'd1,
    MIX_BAL     = 2'd2,
    MIX_ULP     = 2'd3
  } mix_e;
endpackage

// File: rtl/slack_accum.sv
module slack_accum #(
  parameter int TIME_W = 16,
  parameter int BAL_W  = TIME_W + 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_done,
  input  logic [TIME_W-1:0]       budget,
  input  logic [TIME_W-1:0]       decode_time,
  output logic signed [BAL_W-1:0] bal_q,
  output logic signed [BAL_W-1:0] bal_d
);
  localparam int SUM_W = BAL_W + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((64'sd1 <<< (BAL_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SUM_W'(64'sd1 <<< (BAL_W-1));

  logic signed [TIME_W:0]  delta;
  logic signed [SUM_W-1:0] sum;
  logic signed [BAL_W-1:0] upd;

  always_comb begin
    delta = $signed({1'b0, budget}) - $signed({1'b0, decode_time});
    sum   = SUM_W'(bal_q) + SUM_W'(delta);
    if (sum > SAT_HI)      upd = SAT_HI[BAL_W-1:0];
    else if (sum < SAT_LO) upd = SAT_LO[BAL_W-1:0];
    else                   upd = sum[BAL_W-1:0];
    bal_d = frame_done ? upd : bal_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          bal_q <= '0;
    else if (frame_done) bal_q <= bal_d;
  end

  assert_bal_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(bal_q));

  assert_slack_no_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && decode_time <= budget) |=> bal_q >= $past(bal_q));
endmodule

// File: rtl/mix_threshold.sv
module mix_threshold
  import core_mix_pkg::*;
#(
  parameter int TIME_W = 16,
  parameter int BAL_W  = TIME_W + 3
) (
  input  logic signed [BAL_W-1:0] bal,
  input  logic [TIME_W-1:0]       budget,
  output mix_e                    sel
);
  logic signed [BAL_W-1:0] th_one, th_half, th_two;

  always_comb begin
    th_one  = $signed(BAL_W'(budget));
    th_half = th_one + (th_one >>> 1);
    th_two  = th_one <<< 1;
    if (bal < th_one)       sel = MIX_BIG4;
    else if (bal < th_half) sel = MIX_SMALL4;
    else if (bal < th_two)  sel = MIX_BAL;
    else                    sel = MIX_ULP;
  end
endmodule

// File: rtl/mix_mask_dec.sv
module mix_mask_dec
  import core_mix_pkg::*;
#(
  parameter int N_BIG   = 4,
  parameter int N_SMALL = 4,
  parameter int MASK_W  = N_BIG + N_SMALL
) (
  input  mix_e              code,
  output logic [MASK_W-1:0] mask
);
  always_comb begin
    mask = '0;
    unique case (code)
      MIX_BIG4:   for (int i = 0; i < N_BIG; i++)   mask[i] = 1'b1;
      MIX_SMALL4: for (int i = 0; i < N_SMALL; i++) mask[N_BIG+i] = 1'b1;
      MIX_BAL: begin
        mask[0]     = 1'b1;
        mask[N_BIG] = 1'b1;
      end
      default: begin
        mask[N_BIG]   = 1'b1;
        mask[N_BIG+1] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/core_mix_selector.sv
module core_mix_selector
  import core_mix_pkg::*;
#(
  parameter int TIME_W  = 16,
  parameter int N_BIG   = 4,
  parameter int N_SMALL = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_done,
  input  logic [TIME_W-1:0]         budget,
  input  logic [TIME_W-1:0]         decode_time,
  output logic [1:0]                cfg_code,
  output logic [N_BIG+N_SMALL-1:0]  core_en
);
  localparam int BAL_W  = TIME_W + 3;
  localparam int MASK_W = N_BIG + N_SMALL;

  logic signed [BAL_W-1:0] bal_q, bal_d;
  mix_e sel, cfg_q, cfg_d;
  logic [MASK_W-1:0] mask;

  slack_accum #(.TIME_W(TIME_W), .BAL_W(BAL_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .budget(budget), .decode_time(decode_time),
    .bal_q(bal_q), .bal_d(bal_d)
  );

  mix_threshold #(.TIME_W(TIME_W), .BAL_W(BAL_W)) u_thr (
    .bal(bal_d), .budget(budget), .sel(sel)
  );

  always_comb cfg_d = frame_done ? sel : cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= MIX_ULP;
    else if (frame_done) cfg_q <= cfg_d;
  end

  mix_mask_dec #(.N_BIG(N_BIG), .N_SMALL(N_SMALL), .MASK_W(MASK_W)) u_dec (
    .code(cfg_q), .mask(mask)
  );

  assign cfg_code = cfg_q;
  assign core_en  = mask;

  assert_no_midframe_switch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(cfg_q));

  assert_big4_iff_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> ((cfg_q == MIX_BIG4) == (bal_q < $signed(BAL_W'($past(budget))))));

  assert_ulp_iff_rich_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> ((cfg_q == MIX_ULP) == (bal_q >= $signed(BAL_W'({$past(budget), 1'b0})))));

  assert_mix_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_en[N_BIG-1:0] && |core_en[MASK_W-1:N_BIG]) |-> (cfg_q == MIX_BAL));
endmodule

// File: tb/test_core_mix_selector.sv
module test_core_mix_selector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_done = 1'b0;
  logic [15:0] budget = '0;
  logic [15:0] decode_time = '0;
  logic [1:0] cfg_code;
  logic [7:0] core_en;

  int total = 0;
  int bad = 0;
  longint bal_m = 0;
  int code_m = 3;
  bit done = 1'b0;

  localparam longint BMAX = 262143;
  localparam longint BMIN = -262144;

  always #10 clk = ~clk;

  core_mix_selector i_core_mix_selector (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done),
    .budget(budget), .decode_time(decode_time),
    .cfg_code(cfg_code), .core_en(core_en)
  );

  function automatic int pick(longint b, longint bud);
    longint h = bud + bud / 2;
    if (b < bud) return 0;
    if (b < h) return 1;
    if (b < 2 * bud) return 2;
    return 3;
  endfunction

  function automatic logic [7:0] mask_of(int c);
    case (c)
      0: return 8'h0F;
      1: return 8'hF0;
      2: return 8'h11;
      default: return 8'h30;
    endcase
  endfunction

  task automatic check(string req);
    total++;
    if (cfg_code !== 2'(code_m) || core_en !== mask_of(code_m)) begin
      bad++;
      $display("FAIL %s: code=%0d mask=%h expected code=%0d mask=%h bal=%0d",
               req, cfg_code, core_en, code_m, mask_of(code_m), bal_m);
    end
  endtask

  task automatic frame(input int bud, input int dec, input string req);
    @(negedge clk);
    frame_done = 1'b1; budget = 16'(bud); decode_time = 16'(dec);
    @(negedge clk);
    frame_done = 1'b0;
    bal_m = bal_m + bud - dec;
    if (bal_m > BMAX) bal_m = BMAX;
    if (bal_m < BMIN) bal_m = BMIN;
    code_m = pick(bal_m, bud);
    check(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      budget = 16'($urandom); decode_time = 16'($urandom);
      check("R3 hold without strobe");
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset mix");
    rst_n = 1'b1;
    idle(3);
    // R1/R2: zero start, on-budget frame -> balance 0 < budget
    frame(100, 100, "R1 R4 zero balance");
    // exact thresholds, budget 100
    frame(100, 0,   "R5 tie at one budget");
    frame(100, 50,  "R6 tie at one and a half");
    frame(100, 50,  "R7 tie at two budgets");
    frame(100, 101, "R6 just below two");
    idle(4);
    // odd budget 101: half step = 151 (balance now 199)
    frame(101, 149, "R8 fresh sum 151 odd budget");
    frame(101, 101, "R6 budget change same cycle");
    frame(101, 102, "R5 just below 151");
    frame(101, 101, "R5 steady");
    frame(101, 152, "R4 below one budget");
    frame(101, 2000, "R2 negative balance");
    // saturation high then overshoot through zero
    for (int i = 0; i < 6; i++) frame(65535, 0, "R9 climb to max");
    for (int i = 0; i < 5; i++) frame(0, 65535, "R9 descend from max");
    for (int i = 0; i < 8; i++) frame(0, 65535, "R9 floor");
    for (int i = 0; i < 5; i++) frame(65535, 0, "R9 rise from floor");
    // random traffic
    for (int i = 0; i < 400; i++) begin
      int bud = $urandom_range(4000, 200);
      int dec = $urandom_range(2 * bud, 0);
      frame(bud, dec, "R2 R8 random frame");
      if ($urandom_range(3, 0) == 0) idle($urandom_range(3, 1));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule